// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog whose timeout is set by a single byte-wide setting register. The two lowest bits pick a resolution step and the next five bits give a multiplier. Together they define a timeout of `multiplier * 4^resolution` periods of an external tick input. That tick runs at one sixteenth of a second in the target system. The top bit of the register steers what an expiry does. When it is set, the block raises a one-cycle system reset request, clears the setting register and pulses a clear for a neighbouring control bit. When it is clear, the block gives a one-cycle interrupt pulse.

Software keeps the watchdog alive in one of two ways. It can rewrite the setting register, which also clears the sticky timeout flag. It can also read the flags register, and the block sees that read as a strobe. Both actions reload the countdown. A multiplier of zero turns the watchdog off.

The control is a four-state machine. `WD_IDLE` is disarmed. `WD_RUN` counts ticks down. `WD_FIRE_RST` and `WD_FIRE_IRQ` each last one cycle and issue the expiry action.

The transitions are:
- `arm`: any state goes to `WD_RUN` on a write or a flags read whose timeout is non-zero.
- `disarm`: any state goes to `WD_IDLE` on a write or a flags read whose timeout is zero.
- `expire_rst` and `expire_irq`: `WD_RUN` goes to `WD_FIRE_RST` or `WD_FIRE_IRQ` on the last tick.
- `retire`: either fire state goes back to `WD_IDLE`.

Top module: `wdt_encoded`

## Requirements
- R1: The setting byte holds the resolution in bits 1:0, the multiplier in bits 6:2 and the steering bit in bit 7. After a write, expiry happens on exactly the `multiplier * 2^(2*resolution)`-th tick, and no earlier.
- R2: A write to the setting register clears `wd_flag` and restarts the countdown from the newly written value.
- R3: A `flag_rd` strobe restarts the countdown from the value currently held in the setting register.
- R4: Expiry sets `wd_flag`, and the flag stays set until the next write. A flags read does not clear it.
- R5: On expiry with bit 7 set, `rst_req` and `ctl_clr` are high together for exactly one cycle, and the setting register reads back as 0.
- R6: On expiry with bit 7 clear, `irq` is high for exactly one cycle. The setting register keeps its value and the watchdog does not re-arm by itself.
- R7: A multiplier of zero disables the watchdog, so no tick produces an expiry.
- R8: Priority is write, then flags read, then tick. A tick in the same cycle as a reload is ignored, and when a write and a read coincide the written value is used.
- R9: After reset, the setting register is 0, `wd_flag` is 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the setting register |
| cfg_wdata | input | 8 | Setting byte to write |
| flag_rd | input | 1 | Strobe marking a read of the flags register |
| tick | input | 1 | One-cycle pulse per sixteenth of a second |
| wd_cfg | output | 8 | Current setting register contents |
| wd_flag | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-cycle system reset request |
| ctl_clr | output | 1 | One-cycle clear of the neighbouring control bit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps every multiplier and resolution pair with both steering choices. For each pair it counts ticks up to the exact expiry, so a design that counts one tick too many or too few, or decodes the field shift wrongly, fires at the wrong tick. A multiplier of zero must stay silent for many ticks; a design that underflows the counter would fire right away or after wrap-around. Directed cases make a tick coincide with a reload, and a write coincide with a read. A design with the wrong priority would either lose one tick of the new count or restart from the stale value. The bench also checks that a flags read leaves the flag set, and that the block stays quiet after an interrupt expiry; a design that re-arms by itself would fire again.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int RES_W     = 2;
    localparam int MULT_W    = 5;
    localparam int MULT_LSB  = RES_W;
    localparam int CFG_W     = RES_W + MULT_W + 1;
    localparam int STEER_BIT = CFG_W - 1;
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W     = MULT_W + MAX_SHIFT;

    typedef enum logic [1:0] {
        WD_IDLE     = 2'd0,
        WD_RUN      = 2'd1,
        WD_FIRE_RST = 2'd2,
        WD_FIRE_IRQ = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdt_interval_calc.sv
`timescale 1ns/1ps
module wdt_interval_calc
    import wdt_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    output logic [CNT_W-1:0] ticks,
    output logic             steer
);
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;

    always_comb begin
        mult  = cfg[MULT_LSB +: MULT_W];
        res   = cfg[RES_W-1:0];
        // each resolution step multiplies by four
        ticks = CNT_W'(mult) << {res, 1'b0};
        steer = cfg[STEER_BIT];
    end
endmodule

// File: rtl/wdt_down_counter.sv
`timescale 1ns/1ps
module wdt_down_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/wdt_encoded.sv
`timescale 1ns/1ps
module wdt_encoded
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             flag_rd,
    input  logic             tick,
    output logic [CFG_W-1:0] wd_cfg,
    output logic             wd_flag,
    output logic             rst_req,
    output logic             ctl_clr,
    output logic             irq
);
    wd_state_e        state, state_nxt;
    logic [CFG_W-1:0] cfg_q;
    logic [CNT_W-1:0] new_ticks, cur_ticks, load_val, cnt;
    logic             new_steer, cur_steer;
    logic             load, last, expire;

    wdt_interval_calc u_calc_new (
        .cfg   (cfg_wdata),
        .ticks (new_ticks),
        .steer (new_steer)
    );

    wdt_interval_calc u_calc_cur (
        .cfg   (cfg_q),
        .ticks (cur_ticks),
        .steer (cur_steer)
    );

    // A write beats a flags read, and both beat a tick
    always_comb begin
        load     = cfg_we | flag_rd;
        load_val = cfg_we ? new_ticks : cur_ticks;
    end

    wdt_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (tick && state == WD_RUN),
        .cnt      (cnt),
        .last     (last)
    );

    assign expire = !load && state == WD_RUN && tick && last;

    always_comb begin
        state_nxt = state;
        if (load) begin
            state_nxt = (load_val == '0) ? WD_IDLE : WD_RUN;
        end else begin
            unique case (state)
                WD_IDLE:     state_nxt = WD_IDLE;
                WD_RUN:      if (expire) state_nxt = cur_steer ? WD_FIRE_RST : WD_FIRE_IRQ;
                WD_FIRE_RST: state_nxt = WD_IDLE;
                WD_FIRE_IRQ: state_nxt = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WD_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            wd_flag <= 1'b0;
        end else if (cfg_we) begin
            cfg_q   <= cfg_wdata;
            wd_flag <= 1'b0;
        end else if (expire) begin
            wd_flag <= 1'b1;
            if (cur_steer)
                cfg_q <= '0;
        end
    end

    always_comb begin
        rst_req = 1'b0;
        ctl_clr = 1'b0;
        irq     = 1'b0;
        unique case (state)
            WD_IDLE, WD_RUN: ;
            WD_FIRE_RST: begin
                rst_req = 1'b1;
                ctl_clr = 1'b1;
            end
            WD_FIRE_IRQ: irq = 1'b1;
        endcase
    end

    assign wd_cfg = cfg_q;
endmodule

// File: rtl/wdt_encoded_chk.sv
`timescale 1ns/1ps
module wdt_encoded_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             flag_rd,
    input logic             tick,
    input logic [CFG_W-1:0] wd_cfg,
    input logic             wd_flag,
    input logic             rst_req,
    input logic             ctl_clr,
    input logic             irq
);
    // R2
    wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !wd_flag);

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> (irq || rst_req));

    // R5
    rst_cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (wd_cfg == '0));

    // R5
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6
    action_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    // R7
    zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[MULT_LSB +: MULT_W] == '0) |=> !(irq || rst_req));
endmodule

bind wdt_encoded wdt_encoded_chk u_chk (.*);

// File: tb/wdt_encoded_test.sv
`timescale 1ns/1ps
module wdt_encoded_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] wd_cfg;
    logic       wd_flag, rst_req, ctl_clr, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    wdt_encoded uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .flag_rd(flag_rd), .tick(tick), .wd_cfg(wd_cfg), .wd_flag(wd_flag),
        .rst_req(rst_req), .ctl_clr(ctl_clr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    // applies n back-to-back ticks; returns number of cycles with a pulse
    task automatic run_ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            pulses += int'(irq | rst_req);
        end
        tick = 1'b0;
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        int p;
        @(negedge clk); @(negedge clk);
        // R9 reset state
        check("R9 cfg", wd_cfg, 0);
        check("R9 flag", wd_flag, 0);
        check("R9 pulses", {rst_req, ctl_clr, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R5/R6/R7 sweep over every field combination
        for (int res = 0; res < 4; res++) begin
            for (int mult = 0; mult < 32; mult++) begin
                logic       st;
                logic [7:0] v;
                int         n;
                st = 1'(mult ^ res);
                v  = {st, 5'(mult), 2'(res)};
                n  = mult * (1 << (2 * res));
                do_write(v);
                check("R2 flag cleared by write", wd_flag, 0);
                if (n == 0) begin
                    run_ticks(70, p);
                    check("R7 disabled pulses", p, 0);
                    check("R7 disabled flag", wd_flag, 0);
                end else begin
                    run_ticks(n - 1, p);
                    check("R1 no early expiry", p, 0);
                    one_tick();
                    check("R1 expiry on last tick", int'(rst_req | irq), 1);
                    check("R4 flag set", wd_flag, 1);
                    if (st) begin
                        check("R5 reset pulse", {rst_req, ctl_clr, irq}, 3'b110);
                        check("R5 cfg cleared", wd_cfg, 0);
                    end else begin
                        check("R6 irq pulse", {rst_req, ctl_clr, irq}, 3'b001);
                        check("R6 cfg kept", wd_cfg, int'(v));
                    end
                    @(negedge clk);
                    check("R5 R6 single cycle", {rst_req, ctl_clr, irq}, 0);
                end
            end
        end

        // R6 no self re-arm after interrupt expiry
        do_write(8'h04);
        one_tick();
        check("R6 irq", irq, 1);
        run_ticks(20, p);
        check("R6 no re-arm", p, 0);

        // R3 flags read restarts with held value; R4 flag kept by read
        do_write(8'h0C);
        run_ticks(2, p);
        do_read();
        run_ticks(2, p);
        check("R3 restart by read", p, 0);
        one_tick();
        check("R3 expiry after read", irq, 1);
        do_read();
        check("R4 flag survives read", wd_flag, 1);
        run_ticks(2, p);
        check("R3 second countdown", p, 0);
        one_tick();
        check("R3 second expiry", irq, 1);

        // R8 tick coinciding with a write is ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h08; tick = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; tick = 1'b0;
        run_ticks(1, p);
        check("R8 tick with write ignored", p, 0);
        one_tick();
        check("R8 expiry after full count", irq, 1);

        // R8 tick coinciding with a read is ignored
        do_write(8'h08);
        run_ticks(1, p);
        @(negedge clk);
        flag_rd = 1'b1; tick = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0; tick = 1'b0;
        run_ticks(1, p);
        check("R8 tick with read ignored", p, 0);
        one_tick();
        check("R8 expiry after read reload", irq, 1);

        // R8 write beats read: zero multiplier written while reading
        do_write(8'h04);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h03; flag_rd = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; flag_rd = 1'b0;
        run_ticks(10, p);
        check("R8 write wins over read", p, 0);
        check("R8 cfg written", wd_cfg, 8'h03);

        // R5 after a reset-steered expiry a read leaves it disarmed
        do_write(8'h84);
        one_tick();
        check("R5 reset request", {rst_req, ctl_clr}, 2'b11);
        do_read();
        run_ticks(10, p);
        check("R5 stays disarmed", p, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYC; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule